// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two component predictors. The first is a per-branch history predictor. A table indexed by branch address holds a short outcome history for each branch, and that history selects a two-bit counter in a pattern table. The second is a shared-history predictor: a single register holds the most recent outcomes of all branches, and it indexes its own counter table. A third table of two-bit counters, indexed by branch address, learns for each branch which of the two components to trust. The final prediction is the answer of the component it selects.

Prediction is a combinational lookup. The fetch stage presents an address, and in the same cycle it gets the final direction, which component was chosen, and both component answers. The fetch stage keeps the two component answers with the branch. When the branch resolves, the back end returns them on the update port together with the address and the real outcome. Every valid update trains both component tables, shifts both histories and, where the components disagreed, steps the chooser. Target prediction and history repair after a flush are left to the surrounding logic.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken) and both histories are zero. Any address therefore predicts not taken, with `pred_use_global`=0 and both component answers 0.
- R2: The per-branch history of an address is selected by address bits [11:2]. It is 10 bits wide. On a valid update it shifts left and takes the outcome into bit 0. The local pattern counter indexed by that history gives the local answer, which is its bit 1.
- R3: The shared history is 12 bits wide. On every valid update it shifts left and takes the outcome into bit 0. It directly indexes the global counter table, whose bit 1 is the global answer.
- R4: Each counter counts up on a taken outcome and down on a not-taken one, saturating at 3 and at 0. An update trains the local counter selected by the branch's history before the shift, and the global counter selected by the shared history before the shift.
- R5: The chooser counter is selected by address bits [11:2]. Its bit 1 set selects the global component. `pred_taken` equals the answer of the selected component.
- R6: The chooser moves by one step toward the component whose returned answer matched the outcome, and only when the two returned answers differ. When they agree it is unchanged.
- R7: Every valid update trains both component tables and both histories, whichever component was chosen.
- R8: A prediction made in the same cycle as an update sees the state from before that update. The update shows on the outputs from the next cycle.
- R9: When `upd_valid` is low, no table or history changes, whatever the other update inputs carry.
- R10: A branch that alternates taken and not taken is, after training, predicted correctly by the local component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_addr | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Final direction prediction |
| pred_use_global | output | 1 | 1 when the global component was chosen |
| pred_local | output | 1 | Local component answer |
| pred_global | output | 1 | Global component answer |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_local_pred | input | 1 | Local answer given at prediction time |
| upd_global_pred | input | 1 | Global answer given at prediction time |

## Verification
A lookup and a training update can fall in the same cycle, and they may address the same branch. The bench provokes this by predicting an address while it updates that same address, on repeated taken outcomes, on an alternating pattern and on random traffic. It also drives disagreeing component answers into the update port to step the chooser while the same branch is being looked up. A reference model in the bench is applied only after each expected value has been captured. Every comparison therefore checks that a same-cycle lookup returns the state from before the update, and that the trained state shows on the next cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'b01;

    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        ctr2_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'd1;
        else    r = (c == 2'b00) ? c : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem_q [DEPTH];
    ctr2_t wr_val_d;

    always_comb begin
        wr_val_d = ctr_step(mem_q[wr_idx], wr_up);
    end

    assign rd_ctr = mem_q[rd_idx];

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_val_d;
        end
    end

endmodule

// File: rtl/bp_local_comp.sv
module bp_local_comp
    import bp_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             pred_dir,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] hist_d;
    logic [HIST_W-1:0] pred_hist;
    logic [HIST_W-1:0] upd_hist;
    ctr2_t             pred_ctr;

    assign pred_hist = hist_q[pred_idx];
    assign upd_hist  = hist_q[upd_idx];

    always_comb begin
        hist_d = {upd_hist[HIST_W-2:0], upd_taken};
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (upd_en) begin
            hist_q[upd_idx] <= hist_d;
        end
    end

    bp_ctr_table #(.IDX_W(HIST_W)) u_pht (
        .clk    (clk),
        .rst_ni (rst_ni),
        .rd_idx (pred_hist),
        .rd_ctr (pred_ctr),
        .wr_en  (upd_en),
        .wr_idx (upd_hist),
        .wr_up  (upd_taken)
    );

    assign pred_dir = pred_ctr[1];

endmodule

// File: rtl/bp_global_comp.sv
module bp_global_comp
    import bp_pkg::*;
#(
    parameter int HIST_W = 12
) (
    input  logic clk,
    input  logic rst_ni,
    output logic pred_dir,
    input  logic upd_en,
    input  logic upd_taken
);
    typedef struct packed {
        logic [HIST_W-1:0] ghist;
    } gstate_t;

    gstate_t state_d, state_q;
    ctr2_t   pred_ctr;

    always_comb begin
        state_d = state_q;
        if (upd_en) state_d.ghist = {state_q.ghist[HIST_W-2:0], upd_taken};
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    bp_ctr_table #(.IDX_W(HIST_W)) u_pht (
        .clk    (clk),
        .rst_ni (rst_ni),
        .rd_idx (state_q.ghist),
        .rd_ctr (pred_ctr),
        .wr_en  (upd_en),
        .wr_idx (state_q.ghist),
        .wr_up  (upd_taken)
    );

    assign pred_dir = pred_ctr[1];

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
    import bp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ADDR_LSB  = 2,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int GHIST_W   = 12,
    parameter int CH_IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic              pred_use_global,
    output logic              pred_local,
    output logic              pred_global,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic              upd_local_pred,
    input  logic              upd_global_pred
);
    logic [LHT_IDX_W-1:0] pred_lidx, upd_lidx;
    logic [CH_IDX_W-1:0]  pred_cidx, upd_cidx;
    ctr2_t                ch_ctr;
    logic                 ch_wr_en;
    logic                 ch_toward_global;

    assign pred_lidx = pred_addr[ADDR_LSB +: LHT_IDX_W];
    assign upd_lidx  = upd_addr[ADDR_LSB +: LHT_IDX_W];
    assign pred_cidx = pred_addr[ADDR_LSB +: CH_IDX_W];
    assign upd_cidx  = upd_addr[ADDR_LSB +: CH_IDX_W];

    bp_local_comp #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_local (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .pred_idx  (pred_lidx),
        .pred_dir  (pred_local),
        .upd_en    (upd_valid),
        .upd_idx   (upd_lidx),
        .upd_taken (upd_taken)
    );

    bp_global_comp #(.HIST_W(GHIST_W)) u_global (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .pred_dir  (pred_global),
        .upd_en    (upd_valid),
        .upd_taken (upd_taken)
    );

    always_comb begin
        ch_wr_en         = upd_valid && (upd_local_pred != upd_global_pred);
        ch_toward_global = (upd_global_pred == upd_taken);
    end

    bp_ctr_table #(.IDX_W(CH_IDX_W)) u_chooser (
        .clk    (clk),
        .rst_ni (rst_ni),
        .rd_idx (pred_cidx),
        .rd_ctr (ch_ctr),
        .wr_en  (ch_wr_en),
        .wr_idx (upd_cidx),
        .wr_up  (ch_toward_global)
    );

    assign pred_use_global = ch_ctr[1];
    assign pred_taken      = pred_use_global ? pred_global : pred_local;

endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
    parameter int ADDR_W   = 32,
    parameter int ADDR_LSB = 2,
    parameter int CH_IDX_W = 10
) (
    input logic              clk,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] pred_addr,
    input logic              pred_taken,
    input logic              pred_use_global,
    input logic              pred_local,
    input logic              pred_global,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_addr,
    input logic              upd_taken,
    input logic              upd_local_pred,
    input logic              upd_global_pred
);
    logic same_ch_idx;
    assign same_ch_idx = pred_addr[ADDR_LSB +: CH_IDX_W] == upd_addr[ADDR_LSB +: CH_IDX_W];

    // R1: first cycle out of reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_ni)
        !$past(rst_ni) |-> (!pred_taken && !pred_use_global && !pred_local && !pred_global));

    // R9: without a valid update and with a steady address, outputs hold
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
        (!$past(upd_valid) && $stable(pred_addr))
        |-> $stable({pred_taken, pred_use_global, pred_local, pred_global}));

    // R6: an agreeing update never moves the chooser
    p_chooser_agree_r6: assert property (@(posedge clk) disable iff (!rst_ni)
        ($stable(pred_addr) && (!$past(upd_valid) || ($past(upd_local_pred) == $past(upd_global_pred))))
        |-> $stable(pred_use_global));

    // R6: global-correct disagreement cannot turn selection away from global
    p_chooser_to_global_r6: assert property (@(posedge clk) disable iff (!rst_ni)
        ($stable(pred_addr) && $past(upd_valid && same_ch_idx && (upd_local_pred != upd_global_pred)
                                     && (upd_global_pred == upd_taken)))
        |-> !$fell(pred_use_global));

    // R6: local-correct disagreement cannot turn selection toward global
    p_chooser_to_local_r6: assert property (@(posedge clk) disable iff (!rst_ni)
        ($stable(pred_addr) && $past(upd_valid && same_ch_idx && (upd_local_pred != upd_global_pred)
                                     && (upd_local_pred == upd_taken)))
        |-> !$rose(pred_use_global));

endmodule

bind tourney_bp tourney_bp_chk #(
    .ADDR_W   (ADDR_W),
    .ADDR_LSB (ADDR_LSB),
    .CH_IDX_W (CH_IDX_W)
) u_chk (
    .clk             (clk),
    .rst_ni          (rst_ni),
    .pred_addr       (pred_addr),
    .pred_taken      (pred_taken),
    .pred_use_global (pred_use_global),
    .pred_local      (pred_local),
    .pred_global     (pred_global),
    .upd_valid       (upd_valid),
    .upd_addr        (upd_addr),
    .upd_taken       (upd_taken),
    .upd_local_pred  (upd_local_pred),
    .upd_global_pred (upd_global_pred)
);

// File: tb/tourney_bp_tb.sv
module tourney_bp_tb;

    localparam int LIDX_W = 10;
    localparam int LH_W   = 10;
    localparam int GH_W   = 12;
    localparam int CIDX_W = 10;

    typedef struct {
        logic  taken;
        logic  src;
        logic  lp;
        logic  gp;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] pred_addr = '0;
    logic        pred_taken, pred_use_global, pred_local, pred_global;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic        upd_local_pred = 1'b0;
    logic        upd_global_pred = 1'b0;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t q[$];

    // reference model state
    logic [LH_W-1:0] m_lht  [1 << LIDX_W];
    logic [1:0]      m_lpht [1 << LH_W];
    logic [1:0]      m_gpht [1 << GH_W];
    logic [1:0]      m_ch   [1 << CIDX_W];
    logic [GH_W-1:0] m_gh;

    always #10 clk = ~clk;   // 50 MHz

    tourney_bp u_dut (
        .clk(clk), .rst_ni(rst_ni), .pred_addr(pred_addr),
        .pred_taken(pred_taken), .pred_use_global(pred_use_global),
        .pred_local(pred_local), .pred_global(pred_global),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
        .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred)
    );

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < (1 << LIDX_W); i++) m_lht[i] = '0;
        for (int i = 0; i < (1 << LH_W); i++)   m_lpht[i] = 2'b01;
        for (int i = 0; i < (1 << GH_W); i++)   m_gpht[i] = 2'b01;
        for (int i = 0; i < (1 << CIDX_W); i++) m_ch[i] = 2'b01;
        m_gh = '0;
    endfunction

    function automatic exp_t model_pred(logic [31:0] a);
        exp_t e;
        e.lp    = m_lpht[m_lht[a[11:2]]][1];
        e.gp    = m_gpht[m_gh][1];
        e.src   = m_ch[a[11:2]][1];
        e.taken = e.src ? e.gp : e.lp;
        e.tag   = "";
        return e;
    endfunction

    function automatic void model_upd(logic [31:0] a, logic t, logic lp, logic gp);
        logic [LH_W-1:0] h;
        h = m_lht[a[11:2]];
        m_lpht[h] = sat(m_lpht[h], t);
        m_lht[a[11:2]] = {h[LH_W-2:0], t};
        m_gpht[m_gh] = sat(m_gpht[m_gh], t);
        m_gh = {m_gh[GH_W-2:0], t};
        if (lp != gp) m_ch[a[11:2]] = sat(m_ch[a[11:2]], gp == t);
    endfunction

    // driver: one lookup (and optional update) per cycle, expected value queued
    task automatic step(input logic [31:0] pa, input logic uv, input logic [31:0] ua,
                        input logic ut, input logic force_p, input logic fl,
                        input logic fg, input string tag);
        exp_t e, u;
        logic lp, gp;
        @(negedge clk);
        e = model_pred(pa);
        e.tag = tag;
        u = model_pred(ua);
        lp = force_p ? fl : u.lp;
        gp = force_p ? fg : u.gp;
        pred_addr = pa; upd_valid = uv; upd_addr = ua; upd_taken = ut;
        upd_local_pred = lp; upd_global_pred = gp;
        q.push_back(e);
        if (uv) model_upd(ua, ut, lp, gp);
    endtask

    // monitor: compare away from the rising edge
    always @(negedge clk) begin : mon
        exp_t e;
        #5;
        while (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if ({pred_taken, pred_use_global, pred_local, pred_global} !== {e.taken, e.src, e.lp, e.gp}) begin
                n_fail++;
                $display("FAIL %s: got taken/src/local/global=%b%b%b%b expected %b%b%b%b",
                         e.tag, pred_taken, pred_use_global, pred_local, pred_global,
                         e.taken, e.src, e.lp, e.gp);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R1: reset state at several addresses
        step(32'h100, 0, 32'h0, 0, 0, 0, 0, "R1");
        step(32'h3fc, 0, 32'h0, 0, 0, 0, 0, "R1");

        // R8 R4: lookup and update of the same branch in the same cycle
        for (int i = 0; i < 12; i++) step(32'h40, 1, 32'h40, 1, 0, 0, 0, "R8 R4");
        // R4: saturated counter survives one not-taken
        step(32'h40, 1, 32'h40, 0, 0, 0, 0, "R4");
        step(32'h40, 0, 32'h0, 0, 0, 0, 0, "R4");

        // R10 R2: alternating branch learned by the local history
        for (int i = 0; i < 60; i++) step(32'h80, 1, 32'h80, i[0], 0, 0, 0, "R10 R2");
        step(32'h80, 0, 32'h0, 0, 0, 0, 0, "R10");

        // R6 R5: disagreement with global correct moves chooser to global
        for (int i = 0; i < 2; i++) step(32'h200, 1, 32'h200, 1, 1, 0, 1, "R6");
        step(32'h200, 0, 32'h0, 0, 0, 0, 0, "R6 R5");
        // R6: agreement leaves chooser unchanged
        for (int i = 0; i < 3; i++) step(32'h200, 1, 32'h200, 0, 1, 1, 1, "R6");
        step(32'h200, 0, 32'h0, 0, 0, 0, 0, "R6");
        // R6: local correct moves it back
        for (int i = 0; i < 3; i++) step(32'h200, 1, 32'h200, 0, 1, 0, 1, "R6");
        step(32'h200, 0, 32'h0, 0, 0, 0, 0, "R6");

        // R9: invalid update with busy fields changes nothing
        for (int i = 0; i < 6; i++) step(32'h200, 0, 32'h200 + i * 4, i[0], 1, i[1], ~i[1], "R9");
        step(32'h40, 0, 32'h40, 1, 1, 0, 1, "R9");

        // R2 R3 R5 R7: mixed traffic over several branches
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic        t;
            case (i % 4)
                0: begin a = 32'h1000; t = (i % 12) != 0; end
                1: begin a = 32'h1004; t = $urandom_range(0, 1) == 1; end
                2: begin a = 32'h2008; t = ((i / 4) % 2) == 0; end
                default: begin a = 32'h300c; t = 1'b0; end
            endcase
            step(a, 1, a, t, 0, 0, 0, "R2 R3 R5 R7");
            if (i % 7 == 0) step(32'h1004, 0, 32'h0, 0, 0, 0, 0, "R3 R7");
        end

        step(32'h1000, 0, 32'h0, 0, 0, 0, 0, "R5");
        @(negedge clk);
        #8;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule